// File: doc/BRIEF.md
# USB Low-Speed Packet Receiver

This block recovers one low-speed USB packet at a time from the two bus data lines and passes it on a byte at a time. The clock runs at eight times the 1.5 Mbit/s bit rate. Both lines pass through a two-stage synchronizer first. The receiver then waits until D- is high, which means the bus is idle or in SE1. Only after that does it hunt for a falling edge on D-.

After each falling edge it samples one and a half bit times later. If the line is still in the K state, it has seen the closing double-K of the sync field. It then starts sampling once per bit, near the centre of each bit. If the line is not in the K state, it goes back to hunting. Recovered bits are NRZI-decoded and unstuffed, then shifted into bytes least-significant bit first. Each complete byte appears as a one-cycle strobe together with its position in the packet.

A single-ended zero ends the packet. The receiver then reports the number of whole bytes with a one-cycle done pulse. A packet longer than the buffer is abandoned with an overflow pulse and gives no done pulse. The packet identifier, the CRC and any handshake are left to downstream logic.

Top module: `usb_ls_rx`

## Requirements
- R1: While reset is held and on the first cycle after it, rx_valid, rx_done and rx_overflow are all low.
- R2: Capture starts only when, after D- has been seen high, a falling edge of D- is followed one bit time later by a K state (D+ high, D- low). If the state one bit later is not K, the receiver resumes hunting and produces no output.
- R3: Each data bit is 1 when D- did not change from the previous bit and 0 when it changed. The last sync bit (K) counts as the previous bit for the first data bit. Bits fill each byte from bit 0 upward, and byte n of the packet is presented on rx_data with rx_index equal to n.
- R4: After six consecutive decoded ones, the next bit is discarded. The closing sync bit counts as one of those ones, and the run may cross a byte boundary.
- R5: A sample with both lines low ends the packet. rx_done pulses for one cycle with rx_len equal to the number of whole bytes. Any trailing partial byte is dropped.
- R6: When byte number BUF_BYTES+1 completes, rx_overflow pulses for one cycle. That byte is not presented, no rx_done follows for the packet, and the receiver waits for the next packet.
- R7: If no falling edge of D- is found within eight bit times of hunting, the receiver returns to waiting for D- high. It produces no output and still accepts the next packet.
- R8: rx_index never reaches BUF_BYTES, and within a packet the indices run 0, 1, 2, ... without gaps.
- R9: rx_valid, rx_done and rx_overflow are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, eight times the bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| usb_dp | input | 1 | D+ line, asynchronous |
| usb_dm | input | 1 | D- line, asynchronous |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_data | output | 8 | Received byte |
| rx_index | output | CNT_W | Position of the byte in the packet, from 0 |
| rx_done | output | 1 | One-cycle pulse at the end of a packet |
| rx_len | output | CNT_W | Number of whole bytes, valid with rx_done |
| rx_overflow | output | 1 | One-cycle pulse when a packet is dropped for length |

## Verification
The main test uses random packet lengths up to the buffer size. Random bytes are mixed with many 0xFF bytes, which exercise unstuffing at varied positions and across byte boundaries.

Directed packets cover the following:
- An empty packet and an all-zero byte, which separate the counting from the toggle decoding.
- A packet exactly the buffer size next to one a byte longer, which pins the overflow boundary.
- Trailing partial bits, which show that they are dropped from the length.

Two preambles lack the double K: one toggles J and K without the closing K pair, and the other is a long idle. Each is followed by a clean packet. This shows that false starts and hunt timeouts emit nothing and leave the receiver ready.

// File: rtl/usb_ls_rx_pkg.sv
// Shared types for the low-speed receiver.
// Line states are coded as {D+, D-}, so bit 0 is always the D- level.
package usb_ls_rx_pkg;

    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_J   = 2'b01,
        LS_K   = 2'b10,
        LS_SE1 = 2'b11
    } line_t;

    typedef enum logic [1:0] {
        ST_WAIT_J,
        ST_HUNT,
        ST_CHECK,
        ST_RECV
    } rx_st_t;

endpackage

// File: rtl/usb_ls_rx_sync.sv
// Multi-stage synchronizer for asynchronous inputs.
// Assumes each bit is independent; the reset value is all zeros.
module usb_ls_rx_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the raw inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/usb_ls_rx_front.sv
// Bit-timing front end.
// Waits for D- high, then hunts for a falling edge of D- with a timeout.
// It confirms the closing double-K of sync by sampling 1.5 bit times after
// the edge. Once in receive, it issues one sample strobe per bit.
// Assumes OVS samples per bit. A strobe that carries SE0, or an abort from
// the deserializer, returns it to waiting.
module usb_ls_rx_front
    import usb_ls_rx_pkg::*;
#(
    parameter int OVS       = 8,
    parameter int HUNT_BITS = 8
) (
    input  logic  clk,
    input  logic  rst_n,
    input  line_t ls,
    input  logic  abort,
    output logic  start,
    output logic  smp_stb,
    output line_t smp_ls
);
    localparam int PH_W     = $clog2(2*OVS + 1);
    localparam int HUNT_LIM = OVS * HUNT_BITS;
    localparam int HT_W     = $clog2(HUNT_LIM + 1);
    localparam logic [PH_W-1:0] CHK_AT  = PH_W'(OVS + OVS/2);
    localparam logic [PH_W-1:0] BIT_AT  = PH_W'(OVS);
    localparam logic [HT_W-1:0] HUNT_END = HT_W'(HUNT_LIM - 1);

    rx_st_t          st;
    logic [PH_W-1:0] ph;
    logic [HT_W-1:0] hunt;

    // State machine: idle wait, edge hunt, sync check, per-bit sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_WAIT_J;
            ph      <= '0;
            hunt    <= '0;
            start   <= 1'b0;
            smp_stb <= 1'b0;
            smp_ls  <= LS_SE0;
        end else begin
            start   <= 1'b0;
            smp_stb <= 1'b0;
            case (st)
                ST_WAIT_J: begin
                    if (ls[0]) begin
                        st   <= ST_HUNT;
                        hunt <= '0;
                    end
                end
                ST_HUNT: begin
                    if (!ls[0]) begin
                        st <= ST_CHECK;
                        ph <= PH_W'(1);
                    end else if (hunt == HUNT_END) begin
                        st <= ST_WAIT_J;
                    end else begin
                        hunt <= hunt + 1'b1;
                    end
                end
                ST_CHECK: begin
                    if (ph == CHK_AT) begin
                        if (ls == LS_K) begin
                            st    <= ST_RECV;
                            ph    <= PH_W'(1);
                            start <= 1'b1;
                        end else begin
                            st   <= ST_HUNT;
                            hunt <= '0;
                        end
                    end else begin
                        ph <= ph + 1'b1;
                    end
                end
                default: begin
                    if (abort) begin
                        st <= ST_WAIT_J;
                    end else if (ph == BIT_AT) begin
                        ph      <= PH_W'(1);
                        smp_stb <= 1'b1;
                        smp_ls  <= ls;
                        if (ls == LS_SE0) st <= ST_WAIT_J;
                    end else begin
                        ph <= ph + 1'b1;
                    end
                end
            endcase
        end
    end

    // R2: receive is entered only from the check state with K on the line
    assert_recv_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RECV && $past(st) != ST_RECV) |-> ($past(st) == ST_CHECK && $past(ls) == LS_K));

    // R7: the hunt counter never runs past its window
    assert_hunt_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HUNT) |-> (hunt <= HUNT_END));

    // R3: sample strobes are isolated pulses
    assert_strobe_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb |=> !smp_stb);
endmodule

// File: rtl/usb_ls_rx_deser.sv
// NRZI decoder, bit unstuffer and byte assembler.
// Assumes 'start' comes one bit time before the first data sample, with
// the line in K. It counts whole bytes, ends on an SE0 sample and aborts
// when the byte count would exceed BUF_BYTES.
module usb_ls_rx_deser
    import usb_ls_rx_pkg::*;
#(
    parameter int BUF_BYTES = 11,
    parameter int CNT_W     = $clog2(BUF_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             smp_stb,
    input  line_t            smp_ls,
    output logic             byte_vld,
    output logic [7:0]       byte_data,
    output logic [CNT_W-1:0] byte_idx,
    output logic             pkt_done,
    output logic [CNT_W-1:0] pkt_len,
    output logic             ovf_pulse
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(BUF_BYTES);
    localparam logic [2:0]       RUN_MAX = 3'd6;

    logic             prev_dm;
    logic [2:0]       ones;
    logic [2:0]       nbit;
    logic [7:0]       shreg;
    logic [CNT_W-1:0] count;

    logic       bit_now;
    logic       stuffed;
    logic [7:0] next_byte;

    // Decode of the current sample against the previous level.
    always_comb begin
        bit_now   = (smp_ls[0] == prev_dm);
        stuffed   = (ones == RUN_MAX);
        next_byte = {bit_now, shreg[7:1]};
    end

    // Per-bit datapath: drop stuffed bits, assemble bytes, count, end or abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_dm   <= 1'b0;
            ones      <= '0;
            nbit      <= '0;
            shreg     <= '0;
            count     <= '0;
            byte_vld  <= 1'b0;
            byte_data <= '0;
            byte_idx  <= '0;
            pkt_done  <= 1'b0;
            pkt_len   <= '0;
            ovf_pulse <= 1'b0;
        end else begin
            byte_vld  <= 1'b0;
            pkt_done  <= 1'b0;
            ovf_pulse <= 1'b0;
            if (start) begin
                prev_dm <= 1'b0;
                ones    <= 3'd1;
                nbit    <= '0;
                count   <= '0;
            end else if (smp_stb) begin
                if (smp_ls == LS_SE0) begin
                    pkt_done <= 1'b1;
                    pkt_len  <= count;
                end else begin
                    prev_dm <= smp_ls[0];
                    if (stuffed) begin
                        ones <= '0;
                    end else begin
                        ones  <= bit_now ? ones + 3'd1 : 3'd0;
                        shreg <= next_byte;
                        nbit  <= nbit + 3'd1;
                        if (nbit == 3'd7) begin
                            if (count == CNT_MAX) begin
                                ovf_pulse <= 1'b1;
                            end else begin
                                byte_vld  <= 1'b1;
                                byte_data <= next_byte;
                                byte_idx  <= count;
                                count     <= count + 1'b1;
                            end
                        end
                    end
                end
            end
        end
    end

    // R4: the run of ones never exceeds the stuffing limit
    assert_run_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ones <= RUN_MAX);

    // R8: presented indices stay inside the buffer
    assert_index_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> (byte_idx < CNT_MAX));

    // R9: the three result pulses are exclusive
    assert_pulse_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({byte_vld, pkt_done, ovf_pulse}));

    // R6: after an overflow there is no byte or done in the next cycle
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |=> (!byte_vld && !pkt_done));

    // R5: the reported length never exceeds the buffer
    assert_len_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |-> (pkt_len <= CNT_MAX));
endmodule

// File: rtl/usb_ls_rx.sv
// Top of the low-speed packet receiver.
// Connects the synchronizer, the bit-timing front end and the deserializer.
// Assumes clk runs at OVS times the line bit rate.
module usb_ls_rx
    import usb_ls_rx_pkg::*;
#(
    parameter int OVS         = 8,
    parameter int HUNT_BITS   = 8,
    parameter int SYNC_STAGES = 2,
    parameter int BUF_BYTES   = 11,
    parameter int CNT_W       = $clog2(BUF_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             usb_dp,
    input  logic             usb_dm,
    output logic             rx_valid,
    output logic [7:0]       rx_data,
    output logic [CNT_W-1:0] rx_index,
    output logic             rx_done,
    output logic [CNT_W-1:0] rx_len,
    output logic             rx_overflow
);
    logic [1:0] line_q;
    line_t      line_s;
    logic       start;
    logic       smp_stb;
    line_t      smp_ls;

    usb_ls_rx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({usb_dp, usb_dm}),
        .q     (line_q)
    );

    assign line_s = line_t'(line_q);

    usb_ls_rx_front #(.OVS(OVS), .HUNT_BITS(HUNT_BITS)) u_front (
        .clk     (clk),
        .rst_n   (rst_n),
        .ls      (line_s),
        .abort   (rx_overflow),
        .start   (start),
        .smp_stb (smp_stb),
        .smp_ls  (smp_ls)
    );

    usb_ls_rx_deser #(.BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W)) u_deser (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .smp_stb   (smp_stb),
        .smp_ls    (smp_ls),
        .byte_vld  (rx_valid),
        .byte_data (rx_data),
        .byte_idx  (rx_index),
        .pkt_done  (rx_done),
        .pkt_len   (rx_len),
        .ovf_pulse (rx_overflow)
    );

    // R5: done is a single-cycle pulse
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_done);
endmodule

// File: tb/usb_ls_rx_bench.sv
module usb_ls_rx_bench;
    localparam int OVS = 8;
    localparam int BUF = 11;
    localparam int CW  = $clog2(BUF + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          usb_dp = 1'b0;
    logic          usb_dm = 1'b1;
    logic          rx_valid;
    logic [7:0]    rx_data;
    logic [CW-1:0] rx_index;
    logic          rx_done;
    logic [CW-1:0] rx_len;
    logic          rx_overflow;

    usb_ls_rx #(.OVS(OVS), .BUF_BYTES(BUF)) u_usb_ls_rx (
        .clk (clk), .rst_n (rst_n), .usb_dp (usb_dp), .usb_dm (usb_dm),
        .rx_valid (rx_valid), .rx_data (rx_data), .rx_index (rx_index),
        .rx_done (rx_done), .rx_len (rx_len), .rx_overflow (rx_overflow)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [7:0] pkt [16];
    logic [7:0] got [16];
    int n_valid, n_done, n_ovf, got_len;
    bit idx_ok, excl_ok;
    logic tx_lvl;
    int tx_ones;

    // Monitor: outputs change on rising edges, so they are read on falling edges.
    always @(negedge clk) begin
        if (rst_n) begin
            if (int'(rx_valid) + int'(rx_done) + int'(rx_overflow) > 1) excl_ok = 0;
            if (rx_valid) begin
                if (int'(rx_index) < 16) got[rx_index] = rx_data;
                if (int'(rx_index) != n_valid) idx_ok = 0;
                n_valid++;
            end
            if (rx_done) begin
                n_done++;
                got_len = int'(rx_len);
            end
            if (rx_overflow) n_ovf++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_done(input int n);
        return (n <= BUF) ? 1 : 0;
    endfunction

    function automatic int exp_valid(input int n);
        return (n > BUF) ? BUF : n;
    endfunction

    task automatic clear_mon();
        n_valid = 0; n_done = 0; n_ovf = 0; got_len = -1; idx_ok = 1; excl_ok = 1;
    endtask

    task automatic put_dm(input logic lvl);
        usb_dm = lvl;
        usb_dp = ~lvl;
        repeat (OVS) @(negedge clk);
    endtask

    task automatic put_se0();
        usb_dm = 1'b0;
        usb_dp = 1'b0;
        repeat (OVS) @(negedge clk);
    endtask

    // NRZI with stuffing: 0 toggles D-, 1 holds it; a forced toggle follows six ones.
    task automatic send_bit(input logic b);
        if (!b) begin
            tx_lvl = ~tx_lvl;
            tx_ones = 0;
        end else begin
            tx_ones++;
        end
        put_dm(tx_lvl);
        if (tx_ones == 6) begin
            tx_lvl = ~tx_lvl;
            tx_ones = 0;
            put_dm(tx_lvl);
        end
    endtask

    task automatic send_pkt(input int n, input int extra);
        repeat (3) put_dm(1'b1);
        for (int i = 0; i < 3; i++) begin
            put_dm(1'b0);
            put_dm(1'b1);
        end
        put_dm(1'b0);
        put_dm(1'b0);
        tx_lvl = 1'b0;
        tx_ones = 1;
        for (int i = 0; i < n; i++)
            for (int b = 0; b < 8; b++) send_bit(pkt[i][b]);
        for (int i = 0; i < extra; i++) send_bit(1'b0);
        put_se0();
        put_se0();
        repeat (5) put_dm(1'b1);
    endtask

    task automatic run_pkt(input int n, input int extra, input string req);
        clear_mon();
        send_pkt(n, extra);
        chk(n_done == exp_done(n), req, "done pulses", n_done, exp_done(n));
        chk(n_ovf == ((n > BUF) ? 1 : 0), "R6", "overflow pulses", n_ovf, (n > BUF) ? 1 : 0);
        chk(n_valid == exp_valid(n), "R3", "byte strobes", n_valid, exp_valid(n));
        chk(idx_ok, "R8", "index sequence", int'(idx_ok), 1);
        chk(excl_ok, "R9", "pulse exclusivity", int'(excl_ok), 1);
        if (n <= BUF) chk(got_len == n, "R5", "reported length", got_len, n);
        for (int i = 0; i < exp_valid(n); i++)
            chk(got[i] == pkt[i], req, $sformatf("byte %0d", i), int'(got[i]), int'(pkt[i]));
    endtask

    task automatic expect_silent(input string req);
        chk(n_valid + n_done + n_ovf == 0, req, "output after false start", n_valid + n_done + n_ovf, 0);
    endtask

    initial begin
        int unsigned seed;
        int n;
        seed = $urandom(32'd1957);
        clear_mon();
        repeat (5) @(negedge clk);
        // R1: reset state
        chk(!rx_valid && !rx_done && !rx_overflow, "R1", "outputs in reset",
            int'({rx_valid, rx_done, rx_overflow}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rx_valid && !rx_done && !rx_overflow, "R1", "outputs after reset",
            int'({rx_valid, rx_done, rx_overflow}), 0);
        repeat (4) put_dm(1'b1);

        // R5: empty packet
        run_pkt(0, 0, "R5");
        // R3: all-toggle byte
        pkt[0] = 8'h00;
        run_pkt(1, 0, "R3");
        pkt[0] = 8'hA5; pkt[1] = 8'h3C;
        run_pkt(2, 0, "R3");
        // R4: stuffing everywhere, full buffer
        for (int i = 0; i < BUF; i++) pkt[i] = 8'hFF;
        run_pkt(BUF, 0, "R4");
        // R4: run of ones across a byte boundary
        pkt[0] = 8'hE0; pkt[1] = 8'h07; pkt[2] = 8'h7E;
        run_pkt(3, 0, "R4");
        // R5: trailing partial bits are dropped
        pkt[0] = 8'h96; pkt[1] = 8'h01;
        run_pkt(2, 3, "R5");
        // R6: exactly full, then one byte too many, then recovery
        for (int i = 0; i < BUF + 1; i++) pkt[i] = 8'(i * 37 + 5);
        run_pkt(BUF, 0, "R6");
        run_pkt(BUF + 1, 0, "R6");
        pkt[0] = 8'h5A;
        run_pkt(1, 0, "R6");

        // R2: edges without the closing double K
        clear_mon();
        repeat (3) put_dm(1'b1);
        for (int i = 0; i < 4; i++) begin
            put_dm(1'b0);
            put_dm(1'b1);
            put_dm(1'b1);
        end
        repeat (3) put_dm(1'b1);
        expect_silent("R2");
        pkt[0] = 8'hC3; pkt[1] = 8'h11;
        run_pkt(2, 0, "R2");

        // R7: long idle forces hunt timeouts, then a packet
        clear_mon();
        repeat (30) put_dm(1'b1);
        expect_silent("R7");
        pkt[0] = 8'h42;
        run_pkt(1, 0, "R7");

        // Random packets, biased toward 0xFF to hit stuffing (R3, R4)
        for (int k = 0; k < 30; k++) begin
            n = $urandom_range(0, BUF);
            for (int i = 0; i < n; i++)
                pkt[i] = ($urandom_range(0, 2) == 0) ? 8'hFF : 8'($urandom);
            run_pkt(n, $urandom_range(0, 2) == 0 ? 2 : 0, "R3");
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog R5: run did not complete, actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule